// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serialises one byte at a time onto an idle-high asynchronous line. The frame shape and the bit rate are not given as plain numbers. They come from two packed configuration bytes and a 16-bit time constant, in the layout a classic serial-controller register file uses. Software or a surrounding register block drives these inputs. Bytes arrive through a valid/ready handshake.

The bit period is derived from the input clock. The internal channel clock runs at half the input clock. It is divided by the time constant plus two, and then by a selectable multiplier of 1, 16, 32 or 64. Each frame is sent in this order:

- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional odd or even parity bit;
- one or two high stop bits.

The format and the period are captured when a byte is accepted, so the inputs can be rewritten while a frame is still on the line.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset the serial line is high, `tx_ready` is high and `tx_done` is low.
- R2: While idle the line is high. A frame begins with one low start bit, followed by the data bits least significant bit first.
- R3: `cfg_fmt_b[6:5]` selects the number of data bits: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. Data bits above the selected width are not sent.
- R4: `cfg_fmt_a[0]` set adds a parity bit after the data bits. `cfg_fmt_a[1]` set makes it even parity over the sent data bits, and clear makes it odd parity.
- R5: `cfg_fmt_a[3:2]` equal to 11 sends two high stop bits. Every other value sends one.
- R6: Every bit of the frame lasts exactly 2 × (`cfg_tconst` + 2) × M clock cycles. M is 1, 16, 32 or 64 for `cfg_fmt_a[7:6]` = 00, 01, 10 or 11.
- R7: `tx_ready` falls in the cycle after a byte is accepted with transmit enabled. It stays low until the last stop bit ends. It rises again in the same cycle as a one-cycle `tx_done` pulse.
- R8: A byte accepted while `cfg_fmt_b[3]` is clear is discarded. The line stays high and `tx_ready` stays high. `tx_done` pulses in the cycle after the accept.
- R9: Changes to `cfg_fmt_a`, `cfg_fmt_b` or `cfg_tconst` during a frame do not alter that frame. They apply from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the channel clock is half of it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt_a | input | 8 | Parity enable/sense, stop-bit code, clock multiplier |
| cfg_fmt_b | input | 8 | Data-width code and transmit enable |
| cfg_tconst | input | 16 | Rate time constant |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block can accept a byte (idle) |
| tx_serial | output | 1 | Serial line, idle high |
| tx_done | output | 1 | One-cycle pulse: transmitter empty again |

## Verification
The frame check runs over a set of format and rate combinations. Together they cover all four data-width codes, no parity, odd parity and even parity, the stop-bit codes 00, 01, 10 and 11, and all four multipliers with several time constants.

Each bit is sampled in its first and its last clock cycle. This catches a period that is off by one as well as a wrong bit value. Data patterns with set bits above the selected width show whether the width code is decoded in its unusual order. A byte offered with transmit disabled shows the difference between a discard and a stalled handshake. Rewriting every configuration input in the middle of a frame shows whether the format is captured at accept time.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int NB_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            par_en;
        logic            par_even;
        logic            stop2;
    } frame_fmt_t;

endpackage

// File: rtl/cfg_uart_tx_fmt.sv
// Decodes the two packed format bytes into a frame description.
module cfg_uart_tx_fmt
    import cfg_uart_tx_pkg::*;
(
    input  logic [7:0] fmt_a,
    input  logic [7:0] fmt_b,
    output frame_fmt_t fmt,
    output logic       tx_en
);

    always_comb begin
        fmt          = '0;
        fmt.par_en   = fmt_a[0];
        fmt.par_even = fmt_a[1];
        fmt.stop2    = (fmt_a[3:2] == 2'b11);
        // width code is not monotonic: 01 means 7 and 10 means 6
        case (fmt_b[6:5])
            2'b00:   fmt.nbits = NB_W'(5);
            2'b01:   fmt.nbits = NB_W'(7);
            2'b10:   fmt.nbits = NB_W'(6);
            default: fmt.nbits = NB_W'(8);
        endcase
    end

    assign tx_en = fmt_b[3];

    logic unused_fmt_bits;
    assign unused_fmt_bits = ^{fmt_a[7:4], fmt_b[7], fmt_b[4], fmt_b[2:0]};

endmodule

// File: rtl/cfg_uart_tx_rate.sv
// Bit period in input-clock cycles: 2 * (tconst + 2) * multiplier.
module cfg_uart_tx_rate #(
    parameter int TC_W  = 16,
    parameter int PER_W = TC_W + 8
) (
    input  logic [1:0]       mult_sel,
    input  logic [TC_W-1:0]  tconst,
    output logic [PER_W-1:0] period
);

    localparam int NSEL = 4;

    logic [PER_W-1:0] base;
    logic [PER_W-1:0] cand [NSEL];

    assign base = PER_W'(tconst) + PER_W'(2);

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_mult
            // x1 -> shift 1 (half-rate channel clock); x16/x32/x64 -> 5/6/7
            localparam int SH = (g == 0) ? 1 : g + 4;
            assign cand[g] = base << SH;
        end
    endgenerate

    assign period = cand[mult_sel];

endmodule

// File: rtl/cfg_uart_tx_engine.sv
// Frame sequencer: captures format and period at accept, shifts bits out.
module cfg_uart_tx_engine
    import cfg_uart_tx_pkg::*;
#(
    parameter int PER_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_fmt_t        fmt_in,
    input  logic              en_in,
    input  logic [PER_W-1:0]  per_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              valid_in,
    output logic              ready_out,
    output logic              line_out,
    output logic              done_out
);

    typedef struct packed {
        tx_state_e         st;
        frame_fmt_t        fmt;
        logic [PER_W-1:0]  per;
        logic [PER_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [NB_W-1:0]   idx;
        logic              stop_left;
        logic              par;
        logic              line;
        logic              done;
    } eng_t;

    localparam eng_t ENG_RST = '{
        st:        ST_IDLE,
        fmt:       '0,
        per:       '0,
        cnt:       '0,
        sh:        '0,
        idx:       '0,
        stop_left: 1'b0,
        par:       1'b0,
        line:      1'b1,
        done:      1'b0
    };

    eng_t r_d, r_q;

    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] masked;
    logic              par_bit;

    assign mask    = ~({BYTE_W{1'b1}} << fmt_in.nbits);
    assign masked  = data_in & mask;
    assign par_bit = fmt_in.par_even ? (^masked) : ~(^masked);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (valid_in) begin
                if (en_in) begin
                    r_d.st        = ST_START;
                    r_d.fmt       = fmt_in;
                    r_d.per       = per_in;
                    r_d.cnt       = per_in - PER_W'(1);
                    r_d.sh        = data_in;
                    r_d.par       = par_bit;
                    r_d.idx       = '0;
                    r_d.stop_left = fmt_in.stop2;
                    r_d.line      = 1'b0;
                end else begin
                    r_d.done = 1'b1;
                end
            end
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - PER_W'(1);
        end else begin
            r_d.cnt = r_q.per - PER_W'(1);
            case (r_q.st)
                ST_START: begin
                    r_d.st   = ST_DATA;
                    r_d.line = r_q.sh[0];
                    r_d.idx  = '0;
                end
                ST_DATA: begin
                    if (r_q.idx == r_q.fmt.nbits - NB_W'(1)) begin
                        if (r_q.fmt.par_en) begin
                            r_d.st   = ST_PAR;
                            r_d.line = r_q.par;
                        end else begin
                            r_d.st   = ST_STOP;
                            r_d.line = 1'b1;
                        end
                    end else begin
                        r_d.idx  = r_q.idx + NB_W'(1);
                        r_d.sh   = r_q.sh >> 1;
                        r_d.line = r_q.sh[1];
                    end
                end
                ST_PAR: begin
                    r_d.st   = ST_STOP;
                    r_d.line = 1'b1;
                end
                ST_STOP: begin
                    if (r_q.stop_left) begin
                        r_d.stop_left = 1'b0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
                default: begin
                    r_d = ENG_RST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= ENG_RST;
        else        r_q <= r_d;
    end

    assign ready_out = (r_q.st == ST_IDLE);
    assign line_out  = r_q.line;
    assign done_out  = r_q.done;

    // R2: an idle transmitter holds the line high
    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        ready_out |-> line_out);

    // R6: the bit timer never exceeds the captured period while busy
    a_r6_timer_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_out |-> (r_q.cnt < r_q.per));

    // R7: accepting an enabled byte drops ready and starts the low start bit
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ready_out && en_in) |=> (!ready_out && !line_out));

    // R7: ready returns only together with the done pulse
    a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_out) |-> done_out);

    // R7: no done pulse while a frame is in flight
    a_r7_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_out |-> !done_out);

    // R8: a byte offered with transmit disabled is dropped and reported done
    a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ready_out && !en_in) |=> (done_out && ready_out && line_out));

    // R9: the captured format and period hold for the whole frame
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_out |=> (ready_out || ($stable(r_q.fmt) && $stable(r_q.per))));

endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
    import cfg_uart_tx_pkg::*;
#(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      cfg_fmt_a,
    input  logic [7:0]      cfg_fmt_b,
    input  logic [TC_W-1:0] cfg_tconst,
    input  logic [7:0]      tx_data,
    input  logic            tx_valid,
    output logic            tx_ready,
    output logic            tx_serial,
    output logic            tx_done
);

    localparam int PER_W = TC_W + 8;

    frame_fmt_t       fmt;
    logic             tx_en;
    logic [PER_W-1:0] period;

    cfg_uart_tx_fmt i_fmt (
        .fmt_a (cfg_fmt_a),
        .fmt_b (cfg_fmt_b),
        .fmt   (fmt),
        .tx_en (tx_en)
    );

    cfg_uart_tx_rate #(
        .TC_W  (TC_W),
        .PER_W (PER_W)
    ) i_rate (
        .mult_sel (cfg_fmt_a[7:6]),
        .tconst   (cfg_tconst),
        .period   (period)
    );

    cfg_uart_tx_engine #(
        .PER_W (PER_W)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_in    (fmt),
        .en_in     (tx_en),
        .per_in    (period),
        .data_in   (tx_data),
        .valid_in  (tx_valid),
        .ready_out (tx_ready),
        .line_out  (tx_serial),
        .done_out  (tx_done)
    );

endmodule

// File: tb/test_cfg_uart_tx.sv
`timescale 1ns/1ps
module test_cfg_uart_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_fmt_a = 8'h00;
    logic [7:0]  cfg_fmt_b = 8'h68;
    logic [15:0] cfg_tconst = 16'd0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_serial;
    logic        tx_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_uart_tx i_cfg_uart_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_fmt_a  (cfg_fmt_a),
        .cfg_fmt_b  (cfg_fmt_b),
        .cfg_tconst (cfg_tconst),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_serial  (tx_serial),
        .tx_done    (tx_done)
    );

    // {fmt_a, fmt_b, tconst, data}
    localparam logic [39:0] VECS [9] = '{
        {8'h00, 8'h68, 16'd0, 8'hA5},
        {8'h01, 8'h68, 16'd1, 8'h3C},
        {8'h03, 8'h68, 16'd0, 8'h07},
        {8'h0C, 8'h08, 16'd2, 8'hFF},
        {8'h04, 8'h28, 16'd0, 8'h55},
        {8'h4D, 8'h48, 16'd0, 8'h2A},
        {8'h80, 8'h68, 16'd0, 8'h81},
        {8'hC3, 8'h28, 16'd0, 8'h80},
        {8'h08, 8'h68, 16'd5, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int data_width(input logic [7:0] b);
        case (b[6:5])
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int bit_period(input logic [7:0] a, input logic [15:0] tc);
        int m;
        case (a[7:6])
            2'b00:   m = 1;
            2'b01:   m = 16;
            2'b10:   m = 32;
            default: m = 64;
        endcase
        return 2 * (int'(tc) + 2) * m;
    endfunction

    function automatic int frame_len(input logic [7:0] a, input logic [7:0] b);
        return 1 + data_width(b) + int'(a[0]) + ((a[3:2] == 2'b11) ? 2 : 1);
    endfunction

    function automatic logic exp_bit(input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] d, input int k);
        int nb;
        logic [7:0] md;
        nb = data_width(b);
        md = d & 8'((9'h1 << nb) - 9'h1);
        if (k == 0) return 1'b0;
        if (k <= nb) return d[k-1];
        if (a[0] && k == nb + 1) return a[1] ? (^md) : ~(^md);
        return 1'b1;
    endfunction

    function automatic string bit_tag(input logic [7:0] a, input logic [7:0] b, input int k);
        int nb;
        nb = data_width(b);
        if (k == 0) return "R2 start";
        if (k <= nb) return "R3 data";
        if (a[0] && k == nb + 1) return "R4 parity";
        return "R5 stop";
    endfunction

    // Offers one byte and checks the whole frame; scramble rewrites config mid-frame.
    task automatic send_frame(input logic [7:0] a, input logic [7:0] b, input logic [15:0] tc,
                              input logic [7:0] d, input bit scramble);
        int p;
        int t;
        p = bit_period(a, tc);
        t = frame_len(a, b);
        @(negedge clk);
        cfg_fmt_a  = a;
        cfg_fmt_b  = b;
        cfg_tconst = tc;
        tx_data    = d;
        tx_valid   = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        @(negedge clk);
        chk("R7 ready low after accept", 32'(tx_ready), 32'd0);
        if (scramble) begin
            cfg_fmt_a  = 8'hC3;
            cfg_fmt_b  = 8'h08;
            cfg_tconst = 16'd9;
            tx_data    = ~d;
        end
        for (int k = 0; k < t; k++) begin
            chk(scramble ? "R9 first cycle" : bit_tag(a, b, k), 32'(tx_serial), 32'(exp_bit(a, b, d, k)));
            repeat (p - 1) @(negedge clk);
            chk(scramble ? "R9 last cycle" : "R6 last cycle of bit", 32'(tx_serial), 32'(exp_bit(a, b, d, k)));
            @(negedge clk);
        end
        chk("R7 done at frame end", 32'(tx_done), 32'd1);
        chk("R7 ready at frame end", 32'(tx_ready), 32'd1);
        chk("R2 idle line", 32'(tx_serial), 32'd1);
        @(negedge clk);
        chk("R7 done is one cycle", 32'(tx_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        chk("R1 line in reset", 32'(tx_serial), 32'd1);
        chk("R1 ready in reset", 32'(tx_ready), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 line after reset", 32'(tx_serial), 32'd1);
        chk("R1 ready after reset", 32'(tx_ready), 32'd1);
        chk("R1 done after reset", 32'(tx_done), 32'd0);

        for (int i = 0; i < 9; i++) begin
            send_frame(VECS[i][39:32], VECS[i][31:24], VECS[i][23:8], VECS[i][7:0], 1'b0);
        end

        // R8: transmit enable clear discards the byte
        @(negedge clk);
        cfg_fmt_a  = 8'h00;
        cfg_fmt_b  = 8'h60;
        cfg_tconst = 16'd0;
        tx_data    = 8'h00;
        tx_valid   = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        @(negedge clk);
        chk("R8 done pulse on discard", 32'(tx_done), 32'd1);
        chk("R8 ready stays high", 32'(tx_ready), 32'd1);
        chk("R8 line stays high", 32'(tx_serial), 32'd1);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            chk("R8 no frame sent", 32'(tx_serial), 32'd1);
            chk("R8 no further done", 32'(tx_done), 32'd0);
        end

        // R9: config rewritten during a frame
        send_frame(8'h01, 8'h68, 16'd1, 8'h96, 1'b1);
        // the new setting applies to the following frame
        send_frame(8'h02, 8'h48, 16'd0, 8'h3F, 1'b0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule